// File: doc/BRIEF.md
# Parallel Configuration Host Sequencer

This block is the host-side controller that loads a programmable target device through an asynchronous, byte-wide configuration port. A one-cycle `start` makes the block drive the configuration request line low for a fixed time and then release it. It then waits until the target releases its status line. After that it moves configuration bytes from a valid/ready byte stream onto the port. Each byte gets a write strobe, and a byte is sent only while the target's ready/busy line shows ready.

While loading, the block watches the status line for errors. Recovery takes one of two forms, chosen by the `auto_restart` input. In the first, the block waits for the target to release its status line by itself and then streams again, with no new request pulse. In the second, it always issues a fresh request pulse. After the last byte, the block needs both the done line and the init-done line high before it reports success. A retry counter bounds the number of recovery attempts and ends in a terminal failure state. The byte source restarts its stream from the first byte whenever `src_rewind` is high.

The target-side inputs are asynchronous and are synchronised inside the block. All timing is counted in clock cycles, derived from the clock-frequency parameter.

Top module: `cfg_host_seq`

## Requirements
- R1: During and right after reset: `cfg_n`=1, `cfg_wr_n`=1, `cfg_cs_n`=1, `cfg_cs`=0, `s_ready`=0, `src_rewind`=1, and `cfg_busy`, `cfg_ok`, `cfg_fail` all 0.
- R2: After `start`, `cfg_n` stays low for exactly PULSE_US×CLK_HZ/10^6 clock cycles (1000 at the defaults) and then goes high. While it is low, there is no write strobe, no chip select and no `s_ready`.
- R3: No write strobe begins before the status line (`tgt_status_n`) has been released high after `cfg_n` returns high. No strobe ever begins while the status line is low.
- R4: For each accepted byte, `cfg_wr_n` goes low for exactly STROBE_CYC cycles (2 by default). During the strobe `cfg_cs`=1 and `cfg_cs_n`=0, and `cfg_d` holds the accepted byte steady. Bytes reach the target in stream order. A strobe begins only while `tgt_rdy` is high.
- R5: A low status line during loading stops the transfer. No further byte is accepted or strobed until recovery.
- R6: With `auto_restart`=1, if the target releases its status line within ERR_US after an error, the block raises `src_rewind` while it waits. It then reloads from the first byte with no new `cfg_n` pulse.
- R7: With `auto_restart`=1, if the status line is still low ERR_US after an error, the block issues a new `cfg_n` low pulse.
- R8: With `auto_restart`=0, every status error is followed by a new `cfg_n` low pulse.
- R9: Success (`cfg_ok`=1) requires both `tgt_done` and `tgt_init_done` high within DONE_CYC cycles after the last byte. If either is still low, the block issues a new `cfg_n` pulse.
- R10: Once RETRY_MAX recoveries have been used, the next failure sets `cfg_fail`=1 with `cfg_busy`=0 and `cfg_n`=1, and the block stays there until `start`. At the defaults, a target that never completes sees exactly 3 request pulses.
- R11: After success, `cfg_d_hi_oe`=0 (lines 7..1 released), `cfg_d[0]` stays driven at 0, and the chip select is inactive.
- R12: `cfg_busy` is 1 from the cycle after `start` until `cfg_ok` or `cfg_fail` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a configuration |
| auto_restart | input | 1 | 1: wait for the target's own status release after an error; 0: force a new request pulse |
| s_valid | input | 1 | Configuration byte available |
| s_data | input | 8 | Configuration byte |
| s_last | input | 1 | Marks the final byte of the stream |
| s_ready | output | 1 | Byte accepted this cycle |
| src_rewind | output | 1 | Source must restart the stream from the first byte |
| cfg_n | output | 1 | Configuration request, active low |
| cfg_cs | output | 1 | Active-high chip select |
| cfg_cs_n | output | 1 | Active-low chip select |
| cfg_wr_n | output | 1 | Write strobe, active low |
| cfg_d | output | 8 | Data byte to the target; bit 0 is always driven |
| cfg_d_hi_oe | output | 1 | Output enable for data lines 7..1 |
| tgt_status_n | input | 1 | Target status line, low = reset or error |
| tgt_done | input | 1 | Target done line |
| tgt_init_done | input | 1 | Target init-done line |
| tgt_rdy | input | 1 | Target ready (1) / busy (0) |
| cfg_busy | output | 1 | Sequence in progress |
| cfg_ok | output | 1 | Configuration succeeded |
| cfg_fail | output | 1 | Retry limit exhausted |

## Verification
The target model is driven through six load patterns. A clean load establishes the pulse width, strobe width, byte order and the parked data lines. A mid-stream error with a quick status release separates the auto-restart path (one pulse only) from the forced path, which reruns the same error and must show two pulses. An error whose status line never comes back shows the auto-restart timeout falling back to a pulse. Two runs each withhold one of the two completion lines: one lacks done, the other lacks init-done. They show that success needs both lines, and that repeated failure ends in the failure state after a known number of pulses.

// File: rtl/cfg_host_pkg.sv
package cfg_host_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PULSE,
    ST_WAIT_REL,
    ST_LOAD,
    ST_STROBE,
    ST_GAP,
    ST_CHECK,
    ST_ERR_WAIT,
    ST_SUCCESS,
    ST_FAILED
  } cfg_state_e;

  function automatic int unsigned us_to_cycles(input int unsigned clk_hz, input int unsigned us);
    return (clk_hz / 1_000_000) * us;
  endfunction

endpackage

// File: rtl/cfg_sync_bank.sv
module cfg_sync_bank #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/cfg_down_timer.sv
module cfg_down_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  // R2: once expired, the timer stays expired until reloaded
  a_r2_timer_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero);

endmodule

// File: rtl/cfg_retry_ctr.sv
module cfg_retry_ctr #(
  parameter int LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic full
);

  localparam int CW = $clog2(LIMIT + 2);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                          cnt_d = '0;
    else if (inc && cnt_q != CW'(LIMIT)) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign full = (cnt_q == CW'(LIMIT));

  // R10: recovery count never exceeds its limit
  a_r10_retry_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(LIMIT));

endmodule

// File: rtl/cfg_host_seq.sv
module cfg_host_seq
  import cfg_host_pkg::*;
#(
  parameter int CLK_HZ      = 125_000_000,
  parameter int PULSE_US    = 8,
  parameter int ERR_US      = 40,
  parameter int STROBE_CYC  = 2,
  parameter int DONE_CYC    = 256,
  parameter int RETRY_MAX   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       auto_restart,
  input  logic       s_valid,
  input  logic [7:0] s_data,
  input  logic       s_last,
  output logic       s_ready,
  output logic       src_rewind,
  output logic       cfg_n,
  output logic       cfg_cs,
  output logic       cfg_cs_n,
  output logic       cfg_wr_n,
  output logic [7:0] cfg_d,
  output logic       cfg_d_hi_oe,
  input  logic       tgt_status_n,
  input  logic       tgt_done,
  input  logic       tgt_init_done,
  input  logic       tgt_rdy,
  output logic       cfg_busy,
  output logic       cfg_ok,
  output logic       cfg_fail
);

  localparam int PULSE_CYC = us_to_cycles(CLK_HZ, PULSE_US);
  localparam int ERR_CYC   = us_to_cycles(CLK_HZ, ERR_US);
  localparam int GAP_CYC   = SYNC_STAGES + 2;
  localparam int TW        = $clog2(PULSE_CYC + ERR_CYC + DONE_CYC + STROBE_CYC + GAP_CYC + 1);
  localparam logic [TW-1:0] PULSE_LD  = TW'(PULSE_CYC - 1);
  localparam logic [TW-1:0] ERR_LD    = TW'(ERR_CYC - 1);
  localparam logic [TW-1:0] STROBE_LD = TW'(STROBE_CYC - 1);
  localparam logic [TW-1:0] GAP_LD    = TW'(GAP_CYC - 1);
  localparam logic [TW-1:0] DONE_LD   = TW'(DONE_CYC - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_q;
  logic       rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rs_n = rst_q[1];

  // target-side inputs into the clock domain
  logic [3:0] tgt_sync;
  logic       stat_ok, done_ok, init_ok, rdy_ok;
  cfg_sync_bank #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rs_n),
    .d     ({tgt_status_n, tgt_done, tgt_init_done, tgt_rdy}),
    .q     (tgt_sync)
  );
  assign {stat_ok, done_ok, init_ok, rdy_ok} = tgt_sync;

  cfg_state_e    st_q, st_d;
  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic          rty_clr, rty_inc, rty_full;
  logic          accept, flt, flt_soft;
  logic [7:0]    byte_q;
  logic          last_q;

  cfg_down_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rs_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  cfg_retry_ctr #(.LIMIT(RETRY_MAX)) u_retry (
    .clk   (clk),
    .rst_n (rs_n),
    .clr   (rty_clr),
    .inc   (rty_inc),
    .full  (rty_full)
  );

  // next-state logic
  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    rty_clr  = 1'b0;
    rty_inc  = 1'b0;
    accept   = 1'b0;
    flt      = 1'b0;
    flt_soft = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_SUCCESS, ST_FAILED: begin
        if (start) begin
          st_d     = ST_PULSE;
          tmr_load = 1'b1;
          tmr_val  = PULSE_LD;
          rty_clr  = 1'b1;
        end
      end
      ST_PULSE: begin
        if (tmr_zero) begin
          st_d     = ST_WAIT_REL;
          tmr_load = 1'b1;
          tmr_val  = ERR_LD;
        end
      end
      ST_WAIT_REL: begin
        if (stat_ok)       st_d = ST_LOAD;
        else if (tmr_zero) flt  = 1'b1;
      end
      ST_LOAD: begin
        if (!stat_ok) begin
          flt      = 1'b1;
          flt_soft = 1'b1;
        end else if (s_valid && rdy_ok) begin
          accept   = 1'b1;
          st_d     = ST_STROBE;
          tmr_load = 1'b1;
          tmr_val  = STROBE_LD;
        end
      end
      ST_STROBE: begin
        if (tmr_zero) begin
          st_d     = ST_GAP;
          tmr_load = 1'b1;
          tmr_val  = GAP_LD;
        end
      end
      ST_GAP: begin
        if (!stat_ok) begin
          flt      = 1'b1;
          flt_soft = 1'b1;
        end else if (tmr_zero) begin
          if (last_q) begin
            st_d     = ST_CHECK;
            tmr_load = 1'b1;
            tmr_val  = DONE_LD;
          end else begin
            st_d = ST_LOAD;
          end
        end
      end
      ST_CHECK: begin
        if (!stat_ok) begin
          flt      = 1'b1;
          flt_soft = 1'b1;
        end else if (done_ok && init_ok) begin
          st_d = ST_SUCCESS;
        end else if (tmr_zero) begin
          flt = 1'b1;
        end
      end
      ST_ERR_WAIT: begin
        if (stat_ok) begin
          st_d = ST_LOAD;
        end else if (tmr_zero) begin
          st_d     = ST_PULSE;
          tmr_load = 1'b1;
          tmr_val  = PULSE_LD;
        end
      end
      default: st_d = ST_IDLE;
    endcase

    if (flt) begin
      if (rty_full) begin
        st_d = ST_FAILED;
      end else begin
        rty_inc  = 1'b1;
        tmr_load = 1'b1;
        if (flt_soft && auto_restart) begin
          st_d    = ST_ERR_WAIT;
          tmr_val = ERR_LD;
        end else begin
          st_d    = ST_PULSE;
          tmr_val = PULSE_LD;
        end
      end
    end
  end

  // state register
  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) st_q <= ST_IDLE;
    else       st_q <= st_d;
  end

  // byte holding register, enabled on acceptance
  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      byte_q <= '0;
      last_q <= 1'b0;
    end else if (accept) begin
      byte_q <= s_data;
      last_q <= s_last;
    end
  end

  // output decode
  logic on_port, settled;
  assign on_port  = (st_q == ST_LOAD) || (st_q == ST_STROBE) || (st_q == ST_GAP);
  assign settled  = (st_q == ST_IDLE) || (st_q == ST_SUCCESS) || (st_q == ST_FAILED);

  assign s_ready     = accept;
  assign src_rewind  = !(on_port || st_q == ST_CHECK);
  assign cfg_n       = (st_q != ST_PULSE);
  assign cfg_cs      = on_port;
  assign cfg_cs_n    = !on_port;
  assign cfg_wr_n    = (st_q != ST_STROBE);
  assign cfg_d_hi_oe = !settled;
  assign cfg_d       = settled ? 8'h00 : byte_q;
  assign cfg_busy    = !settled;
  assign cfg_ok      = (st_q == ST_SUCCESS);
  assign cfg_fail    = (st_q == ST_FAILED);

  // R2: nothing moves on the port while the request line is low
  a_r2_pulse_quiet: assert property (@(posedge clk) disable iff (!rs_n)
    !cfg_n |-> (cfg_wr_n && cfg_cs_n && !s_ready));

  // R4: a strobe is always framed by an active chip select
  a_r4_strobe_selected: assert property (@(posedge clk) disable iff (!rs_n)
    !cfg_wr_n |-> (cfg_cs && !cfg_cs_n));

  // R4: data does not move during a strobe
  a_r4_data_held: assert property (@(posedge clk) disable iff (!rs_n)
    (!cfg_wr_n && $past(!cfg_wr_n)) |-> $stable(cfg_d));

  // R5: a status error seen while loading blocks the next transfer
  a_r5_stop_on_error: assert property (@(posedge clk) disable iff (!rs_n)
    (st_q == ST_LOAD && !stat_ok) |=> (cfg_wr_n && !s_ready));

  // R10: the failure state is exclusive and idle
  a_r10_fail_idle: assert property (@(posedge clk) disable iff (!rs_n)
    cfg_fail |-> (!cfg_busy && !cfg_ok && cfg_n));

  // R11: after success only bit 0 stays driven, at a fixed level
  a_r11_lsb_parked: assert property (@(posedge clk) disable iff (!rs_n)
    cfg_ok |-> (!cfg_d_hi_oe && cfg_d[0] == 1'b0 && cfg_cs_n));

endmodule

// File: tb/test_cfg_host_seq.sv
module test_cfg_host_seq;

  localparam int NB     = 6;
  localparam int PULSE  = 1000;
  localparam int STRB   = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       auto_restart = 1'b0;
  logic       s_valid, s_last, s_ready, src_rewind;
  logic [7:0] s_data;
  logic       cfg_n, cfg_cs, cfg_cs_n, cfg_wr_n, cfg_d_hi_oe;
  logic [7:0] cfg_d;
  logic       t_status, t_done, t_init, t_rdy;
  logic       cfg_busy, cfg_ok, cfg_fail;

  int n_chk = 0;
  int n_bad = 0;

  // scenario knobs
  int   m_err_at = 0;
  logic m_rel  = 1'b1;
  logic m_done = 1'b1;
  logic m_ini  = 1'b1;
  logic [7:0] base = 8'h11;

  always #4 clk = ~clk;

  cfg_host_seq i_cfg_host_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .auto_restart(auto_restart),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
    .src_rewind(src_rewind), .cfg_n(cfg_n), .cfg_cs(cfg_cs), .cfg_cs_n(cfg_cs_n),
    .cfg_wr_n(cfg_wr_n), .cfg_d(cfg_d), .cfg_d_hi_oe(cfg_d_hi_oe),
    .tgt_status_n(t_status), .tgt_done(t_done), .tgt_init_done(t_init), .tgt_rdy(t_rdy),
    .cfg_busy(cfg_busy), .cfg_ok(cfg_ok), .cfg_fail(cfg_fail)
  );

  // byte source
  int idx;
  assign s_valid = (idx < NB);
  assign s_last  = (idx == NB - 1);
  assign s_data  = base + 8'(idx * 37);
  always @(posedge clk) begin
    if (!rst_n || src_rewind)   idx <= 0;
    else if (s_valid && s_ready) idx <= idx + 1;
  end

  // target model
  logic       wr_q;
  int         t_nb, t_rel, t_bsy;
  logic       err_fired;
  logic [7:0] t_mem [0:7];
  always @(posedge clk) begin
    wr_q <= cfg_wr_n;
    if (!rst_n) begin
      t_status <= 1'b0; t_done <= 1'b0; t_init <= 1'b0; t_rdy <= 1'b1;
      t_nb <= 0; t_rel <= 10; t_bsy <= 0; err_fired <= 1'b0; wr_q <= 1'b1;
    end else begin
      if (start) err_fired <= 1'b0;
      if (!cfg_wr_n) begin
        t_rdy <= 1'b0; t_bsy <= 3;
      end else if (t_bsy != 0) begin
        t_bsy <= t_bsy - 1;
        if (t_bsy == 1) t_rdy <= 1'b1;
      end
      if (!cfg_n) begin
        t_status <= 1'b0; t_done <= 1'b0; t_init <= 1'b0; t_nb <= 0; t_rel <= 10;
      end else begin
        if (!t_status && t_rel != 0) begin
          t_rel <= t_rel - 1;
          if (t_rel == 1) t_status <= 1'b1;
        end
        if (!wr_q && cfg_wr_n) begin
          t_mem[t_nb] <= cfg_d;
          if (!err_fired && m_err_at != 0 && t_nb + 1 == m_err_at) begin
            err_fired <= 1'b1; t_status <= 1'b0; t_rel <= m_rel ? 20 : 0; t_nb <= 0;
          end else begin
            t_nb <= t_nb + 1;
          end
        end
        if (t_nb == NB && t_status) begin
          t_done <= m_done; t_init <= m_ini;
        end
      end
    end
  end

  // port monitor
  logic cq;
  int   n_pulse, lowc, last_low, wc, wmin, wmax, viol;
  always @(posedge clk) begin
    cq <= cfg_n;
    if (!rst_n || start) begin
      n_pulse <= 0; viol <= 0; wmin <= 255; wmax <= 0; lowc <= 0; wc <= 0; last_low <= 0;
    end else begin
      if (cq && !cfg_n) n_pulse <= n_pulse + 1;
      lowc <= cfg_n ? 0 : lowc + 1;
      if (!cq && cfg_n) last_low <= lowc;
      wc <= cfg_wr_n ? 0 : wc + 1;
      if (!wr_q && cfg_wr_n) begin
        if (wc < wmin) wmin <= wc;
        if (wc > wmax) wmax <= wc;
      end
      if (wr_q && !cfg_wr_n && (!t_status || !t_rdy)) viol <= viol + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one configuration run; returns when ok or fail rises
  task automatic run_cfg(input logic au, input int err_at, input logic rel,
                         input logic dn, input logic ini, input logic [7:0] b);
    int waited = 0;
    auto_restart = au; m_err_at = err_at; m_rel = rel; m_done = dn; m_ini = ini; base = b;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(cfg_busy == 1'b1, "R12", "busy after start", int'(cfg_busy), 1);
    while (!cfg_ok && !cfg_fail && waited < 60000) begin
      @(negedge clk);
      waited++;
    end
    chk(waited < 60000, "R12", "run finished", waited, 0);
    chk(cfg_busy == 1'b0, "R12", "busy at end", int'(cfg_busy), 0);
  endtask

  function automatic int mismatches(input logic [7:0] b);
    int m = 0;
    for (int i = 0; i < NB; i++) if (t_mem[i] != b + 8'(i * 37)) m++;
    return m;
  endfunction

  task automatic t_reset();
    chk(cfg_n == 1'b1 && cfg_wr_n == 1'b1, "R1", "cfg_n&wr_n", int'({cfg_n, cfg_wr_n}), 3);
    chk(cfg_cs_n == 1'b1 && cfg_cs == 1'b0, "R1", "cs_n,cs", int'({cfg_cs_n, cfg_cs}), 2);
    chk({cfg_busy, cfg_ok, cfg_fail} == 3'b000, "R1", "status", int'({cfg_busy, cfg_ok, cfg_fail}), 0);
    chk(s_ready == 1'b0 && src_rewind == 1'b1, "R1", "ready,rewind", int'({s_ready, src_rewind}), 1);
  endtask

  task automatic t_nominal();
    run_cfg(1'b0, 0, 1'b1, 1'b1, 1'b1, 8'h11);
    chk(last_low == PULSE, "R2", "request low width", last_low, PULSE);
    chk(n_pulse == 1, "R2", "pulse count", n_pulse, 1);
    chk(viol == 0, "R3", "strobe while status low or busy", viol, 0);
    chk(wmin == STRB && wmax == STRB, "R4", "strobe width min", wmin, STRB);
    chk(mismatches(8'h11) == 0, "R4", "byte order mismatches", mismatches(8'h11), 0);
    chk(cfg_ok == 1'b1, "R9", "success", int'(cfg_ok), 1);
    chk(cfg_d_hi_oe == 1'b0 && cfg_d[0] == 1'b0, "R11", "hi_oe,d0", int'({cfg_d_hi_oe, cfg_d[0]}), 0);
    chk(cfg_cs_n == 1'b1, "R11", "cs_n after success", int'(cfg_cs_n), 1);
  endtask

  task automatic t_auto_retry();
    run_cfg(1'b1, 3, 1'b1, 1'b1, 1'b1, 8'h40);
    chk(n_pulse == 1, "R6", "pulses with auto release", n_pulse, 1);
    chk(viol == 0, "R5", "strobe during error", viol, 0);
    chk(mismatches(8'h40) == 0, "R6", "reloaded bytes mismatches", mismatches(8'h40), 0);
    chk(cfg_ok == 1'b1, "R6", "success", int'(cfg_ok), 1);
  endtask

  task automatic t_auto_timeout();
    run_cfg(1'b1, 2, 1'b0, 1'b1, 1'b1, 8'h07);
    chk(n_pulse == 2, "R7", "pulses after release timeout", n_pulse, 2);
    chk(viol == 0, "R5", "strobe during error", viol, 0);
    chk(cfg_ok == 1'b1, "R7", "success", int'(cfg_ok), 1);
  endtask

  task automatic t_forced_retry();
    run_cfg(1'b0, 4, 1'b1, 1'b1, 1'b1, 8'hA5);
    chk(n_pulse == 2, "R8", "pulses in forced mode", n_pulse, 2);
    chk(last_low == PULSE, "R8", "second pulse width", last_low, PULSE);
    chk(mismatches(8'hA5) == 0, "R8", "bytes mismatches", mismatches(8'hA5), 0);
    chk(cfg_ok == 1'b1, "R8", "success", int'(cfg_ok), 1);
  endtask

  task automatic t_no_init();
    run_cfg(1'b0, 0, 1'b1, 1'b1, 1'b0, 8'h33);
    chk(cfg_ok == 1'b0, "R9", "no success without init-done", int'(cfg_ok), 0);
    chk(cfg_fail == 1'b1, "R10", "fail flag", int'(cfg_fail), 1);
    chk(n_pulse == 3, "R10", "pulses before failing", n_pulse, 3);
    chk(cfg_n == 1'b1, "R10", "request line idle", int'(cfg_n), 1);
    repeat (20) @(negedge clk);
    chk(cfg_fail == 1'b1 && n_pulse == 3, "R10", "failure holds", n_pulse, 3);
  endtask

  task automatic t_no_done();
    run_cfg(1'b1, 0, 1'b1, 1'b0, 1'b1, 8'h5C);
    chk(cfg_ok == 1'b0 && cfg_fail == 1'b1, "R9", "no success without done", int'(cfg_ok), 0);
    chk(n_pulse == 3, "R9", "pulses when done missing", n_pulse, 3);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_nominal();
    t_auto_retry();
    t_auto_timeout();
    t_forced_retry();
    t_no_init();
    t_no_done();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R12 watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule